// File: doc/BRIEF.md
# Byte Lane Aligner and Merger

This block sits between a processor's operand path and a memory bus that can only move 16-bit words. The processor keeps its general registers in memory, so byte operands show up as whole words, and the byte that is wanted may sit in either half. On the load side, the block picks the addressed byte and places it in the upper half of the operand, with zeros below. When the operand is a whole word, or is taken straight from a register, the word passes through untouched.

On the store side, the block takes an 8-bit result carried in the upper half of a word. It folds that result into the word that was read earlier, giving the value for the write phase of a read-modify-write. The other byte keeps its old value. A byte stored straight into a register always lands in that register's upper half. Next to the merged word, the block gives a two-bit lane marker that shows which half changed. The marker is for debug visibility only, since the bus always writes the full word.

The two paths are independent. Each one is a decode stage followed by one output register, so a result appears one clock after its valid strobe. Sequencing the bus cycles is left to the surrounding control logic.

Top module: `byte_lane_unit`

## Requirements
- R1: While reset is high, and on the first edge after it, both valid outputs, both data outputs and the lane marker are all zero.
- R2: On a load, when the word flag is 1 or the addressing-mode field is 2'b00 (register direct), the operand equals the input word unchanged.
- R3: On a memory byte load (word flag 0, mode not 2'b00) with address LSB 0, the operand is the input's bits [15:8] in bits [15:8], with bits [7:0] zero.
- R4: On a memory byte load with address LSB 1, the operand is the input's bits [7:0] moved to bits [15:8], with bits [7:0] zero.
- R5: On a memory byte store with address LSB 0, the merged word is {result[15:8], original[7:0]} and the lane marker is 2'b10 (bit 1 = upper lane, bit 0 = lower lane). For example, 0x55 stored over 0x1234 gives 0x5534.
- R6: On a memory byte store with address LSB 1, the merged word is {original[15:8], result[15:8]} and the lane marker is 2'b01. For example, 0x55 stored over 0x1234 gives 0x1255.
- R7: On a byte store with mode 2'b00, the merged word is {result[15:8], original[7:0]} and the lane marker is 2'b10, whatever the address LSB.
- R8: On a word store, the merged word equals the result and the lane marker is 2'b11. On any byte store, result bits [7:0] have no effect on the output.
- R9: Each valid output is its valid input delayed by exactly one clock.
- R10: While a path's valid input is low, that path's data outputs, and the lane marker on the store path, keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_valid_i | input | 1 | Load request strobe |
| ld_word_i | input | 16 | Word read from the bus |
| ld_mode_i | input | 2 | Addressing-mode field of the operand (2'b00 = register direct) |
| ld_is_word_i | input | 1 | 1 = word operation, 0 = byte operation |
| ld_addr_lsb_i | input | 1 | Effective-address bit 0 |
| ld_valid_o | output | 1 | Load result valid |
| ld_operand_o | output | 16 | Aligned operand |
| st_valid_i | input | 1 | Store request strobe |
| st_result_i | input | 16 | Result, with the byte result in bits [15:8] |
| st_orig_i | input | 16 | Word read earlier from the destination |
| st_mode_i | input | 2 | Addressing-mode field of the destination (2'b00 = register direct) |
| st_is_word_i | input | 1 | 1 = word operation, 0 = byte operation |
| st_addr_lsb_i | input | 1 | Effective-address bit 0 |
| st_valid_o | output | 1 | Merged word valid |
| st_word_o | output | 16 | Word to write back |
| st_lane_o | output | 2 | Changed-lane marker for debug: bit 1 = upper lane, bit 0 = lower lane |

## Verification
The sweep covers every combination of mode, word flag and address LSB, and uses data whose two halves always differ. A lane swap or a missing zero fill therefore shows up as a wrong operand, and does not hide behind matching halves. A register-direct byte at an odd address is the key case on both paths. If the load path sent it through the lane selector, it would return the low byte. If the store path did the same, it would overwrite the register's low byte and report lane 2'b01. The store patterns put junk in the result's low byte, so a design that leaks it into the merged word gets caught. Idle cycles with changed inputs then show whether the output registers really hold.

// File: rtl/blu_pkg.sv
package blu_pkg;
  typedef enum logic [1:0] {
    LSEL_FULL = 2'd0,
    LSEL_HI   = 2'd1,
    LSEL_LO   = 2'd2
  } lane_sel_e;

  localparam logic [1:0] AMODE_REGDIR = 2'b00;
endpackage

// File: rtl/blu_lane_decode.sv
module blu_lane_decode
  import blu_pkg::*;
#(
  parameter bit REG_KEEPS_WORD = 1'b1
) (
  input  logic       is_word,
  input  logic [1:0] amode,
  input  logic       addr_lsb,
  output lane_sel_e  sel
);
  logic is_reg;
  assign is_reg = (amode == AMODE_REGDIR);

  generate
    if (REG_KEEPS_WORD) begin : g_load
      always_comb begin
        if (is_word || is_reg) sel = LSEL_FULL;
        else if (addr_lsb)     sel = LSEL_LO;
        else                   sel = LSEL_HI;
      end
    end else begin : g_store
      always_comb begin
        if (is_word)                sel = LSEL_FULL;
        else if (is_reg || !addr_lsb) sel = LSEL_HI;
        else                        sel = LSEL_LO;
      end
    end
  endgenerate
endmodule

// File: rtl/blu_read_align.sv
module blu_read_align
  import blu_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_word,
  input  lane_sel_e         sel,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_word
);
  localparam int BYTE_W = WORD_W / 2;

  logic [WORD_W-1:0] nxt;

  always_comb begin
    case (sel)
      LSEL_HI: nxt = {in_word[WORD_W-1 -: BYTE_W], {BYTE_W{1'b0}}};
      LSEL_LO: nxt = {in_word[BYTE_W-1:0], {BYTE_W{1'b0}}};
      default: nxt = in_word;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_word  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_word <= nxt;
    end
  end

  // R4
  ld_low_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && sel != LSEL_FULL) |=> (out_word[BYTE_W-1:0] == '0));
endmodule

// File: rtl/blu_write_merge.sv
module blu_write_merge
  import blu_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] result,
  input  logic [WORD_W-1:0] orig,
  input  lane_sel_e         sel,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_word,
  output logic [1:0]        out_lane
);
  localparam int BYTE_W = WORD_W / 2;
  localparam int LANES  = 2;

  logic [WORD_W-1:0] nxt;
  logic [LANES-1:0]  nxt_lane;
  logic [BYTE_W-1:0] res_byte;

  assign res_byte = result[WORD_W-1 -: BYTE_W];

  always_comb begin
    case (sel)
      LSEL_HI: begin
        nxt      = {res_byte, orig[BYTE_W-1:0]};
        nxt_lane = 2'b10;
      end
      LSEL_LO: begin
        nxt      = {orig[WORD_W-1 -: BYTE_W], res_byte};
        nxt_lane = 2'b01;
      end
      default: begin
        nxt      = result;
        nxt_lane = 2'b11;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_word  <= '0;
      out_lane  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_word <= nxt;
        out_lane <= nxt_lane;
      end
    end
  end

  // R5
  st_one_lane_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && sel != LSEL_FULL) |=> ($countones(out_lane) == 1));
  // R10
  st_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(out_word) && $stable(out_lane)));
endmodule

// File: rtl/byte_lane_unit.sv
module byte_lane_unit
  import blu_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_valid_i,
  input  logic [WORD_W-1:0] ld_word_i,
  input  logic [1:0]        ld_mode_i,
  input  logic              ld_is_word_i,
  input  logic              ld_addr_lsb_i,
  output logic              ld_valid_o,
  output logic [WORD_W-1:0] ld_operand_o,
  input  logic              st_valid_i,
  input  logic [WORD_W-1:0] st_result_i,
  input  logic [WORD_W-1:0] st_orig_i,
  input  logic [1:0]        st_mode_i,
  input  logic              st_is_word_i,
  input  logic              st_addr_lsb_i,
  output logic              st_valid_o,
  output logic [WORD_W-1:0] st_word_o,
  output logic [1:0]        st_lane_o
);
  localparam int BYTE_W = WORD_W / 2;

  lane_sel_e ld_sel;
  lane_sel_e st_sel;

  blu_lane_decode #(.REG_KEEPS_WORD(1'b1)) u_ld_dec (
    .is_word  (ld_is_word_i),
    .amode    (ld_mode_i),
    .addr_lsb (ld_addr_lsb_i),
    .sel      (ld_sel)
  );

  blu_lane_decode #(.REG_KEEPS_WORD(1'b0)) u_st_dec (
    .is_word  (st_is_word_i),
    .amode    (st_mode_i),
    .addr_lsb (st_addr_lsb_i),
    .sel      (st_sel)
  );

  blu_read_align #(.WORD_W(WORD_W)) u_align (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (ld_valid_i),
    .in_word   (ld_word_i),
    .sel       (ld_sel),
    .out_valid (ld_valid_o),
    .out_word  (ld_operand_o)
  );

  blu_write_merge #(.WORD_W(WORD_W)) u_merge (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (st_valid_i),
    .result    (st_result_i),
    .orig      (st_orig_i),
    .sel       (st_sel),
    .out_valid (st_valid_o),
    .out_word  (st_word_o),
    .out_lane  (st_lane_o)
  );

  // R9
  ld_latency_chk: assert property (@(posedge clk) disable iff (rst)
    ld_valid_i |=> ld_valid_o);
  // R9
  st_latency_chk: assert property (@(posedge clk) disable iff (rst)
    !st_valid_i |=> !st_valid_o);
  // R2
  ld_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (ld_valid_i && (ld_is_word_i || ld_mode_i == AMODE_REGDIR))
      |=> (ld_operand_o == $past(ld_word_i)));
  // R7
  st_reg_keep_low_chk: assert property (@(posedge clk) disable iff (rst)
    (st_valid_i && !st_is_word_i && st_mode_i == AMODE_REGDIR)
      |=> (st_word_o[BYTE_W-1:0] == $past(st_orig_i[BYTE_W-1:0]) && st_lane_o == 2'b10));
  // R10
  ld_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !ld_valid_i |=> $stable(ld_operand_o));
endmodule

// File: tb/sim_byte_lane_unit.sv
module sim_byte_lane_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ld_valid_i = 1'b0;
  logic [15:0] ld_word_i = '0;
  logic [1:0]  ld_mode_i = '0;
  logic        ld_is_word_i = 1'b0;
  logic        ld_addr_lsb_i = 1'b0;
  logic        ld_valid_o;
  logic [15:0] ld_operand_o;
  logic        st_valid_i = 1'b0;
  logic [15:0] st_result_i = '0;
  logic [15:0] st_orig_i = '0;
  logic [1:0]  st_mode_i = '0;
  logic        st_is_word_i = 1'b0;
  logic        st_addr_lsb_i = 1'b0;
  logic        st_valid_o;
  logic [15:0] st_word_o;
  logic [1:0]  st_lane_o;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  byte_lane_unit u0 (
    .clk(clk), .rst(rst),
    .ld_valid_i(ld_valid_i), .ld_word_i(ld_word_i), .ld_mode_i(ld_mode_i),
    .ld_is_word_i(ld_is_word_i), .ld_addr_lsb_i(ld_addr_lsb_i),
    .ld_valid_o(ld_valid_o), .ld_operand_o(ld_operand_o),
    .st_valid_i(st_valid_i), .st_result_i(st_result_i), .st_orig_i(st_orig_i),
    .st_mode_i(st_mode_i), .st_is_word_i(st_is_word_i), .st_addr_lsb_i(st_addr_lsb_i),
    .st_valid_o(st_valid_o), .st_word_o(st_word_o), .st_lane_o(st_lane_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int exp_ld(int w, int md, int isw, int lsb);
    if (isw != 0 || md == 0) return w;
    if (lsb == 0) return (w / 256) * 256;
    return (w % 256) * 256;
  endfunction

  function automatic int exp_st(int r, int o, int md, int isw, int lsb);
    if (isw != 0) return r;
    if (md == 0 || lsb == 0) return (r / 256) * 256 + (o % 256);
    return (o / 256) * 256 + (r / 256);
  endfunction

  function automatic int exp_lane(int md, int isw, int lsb);
    if (isw != 0) return 3;
    if (md == 0 || lsb == 0) return 2;
    return 1;
  endfunction

  function automatic string tag_ld(int md, int isw, int lsb);
    if (isw != 0 || md == 0) return "R2";
    return (lsb == 0) ? "R3" : "R4";
  endfunction

  function automatic string tag_st(int md, int isw, int lsb);
    if (isw != 0) return "R8";
    if (md == 0) return "R7";
    return (lsb == 0) ? "R5" : "R6";
  endfunction

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        fails++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=<100000", cycles);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    int ew;
    int el;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 ld_valid", int'(ld_valid_o), 0);
    chk("R1 ld_operand", int'(ld_operand_o), 0);
    chk("R1 st_valid", int'(st_valid_o), 0);
    chk("R1 st_word", int'(st_word_o), 0);
    chk("R1 st_lane", int'(st_lane_o), 0);
    rst = 1'b0;

    // Stated examples: 0x55 over 0x1234
    for (int lsb = 0; lsb < 2; lsb++) begin
      st_valid_i = 1'b1; st_result_i = 16'h55A7; st_orig_i = 16'h1234;
      st_mode_i = 2'b01; st_is_word_i = 1'b0; st_addr_lsb_i = lsb[0];
      @(negedge clk);
      if (lsb == 0) chk("R5 example", int'(st_word_o), 16'h5534);
      else          chk("R6 example", int'(st_word_o), 16'h1255);
    end

    for (int md = 0; md < 4; md++)
      for (int isw = 0; isw < 2; isw++)
        for (int lsb = 0; lsb < 2; lsb++)
          for (int k = 0; k < 6; k++) begin
            int w, r, o;
            w = ((k + 1) * 16'h1357) ^ 16'hA5C3;
            w = w % 65536;
            r = ((k + 3) * 16'h2B61) % 65536;
            o = (w ^ 16'h0FF0) % 65536;
            ld_valid_i = 1'b1; ld_word_i = w[15:0]; ld_mode_i = md[1:0];
            ld_is_word_i = isw[0]; ld_addr_lsb_i = lsb[0];
            st_valid_i = 1'b1; st_result_i = r[15:0]; st_orig_i = o[15:0];
            st_mode_i = md[1:0]; st_is_word_i = isw[0]; st_addr_lsb_i = lsb[0];
            @(negedge clk);
            chk("R9 ld_valid", int'(ld_valid_o), 1);
            chk("R9 st_valid", int'(st_valid_o), 1);
            chk(tag_ld(md, isw, lsb), int'(ld_operand_o), exp_ld(w, md, isw, lsb));
            ew = exp_st(r, o, md, isw, lsb);
            el = exp_lane(md, isw, lsb);
            chk(tag_st(md, isw, lsb), int'(st_word_o), ew);
            chk({tag_st(md, isw, lsb), " lane"}, int'(st_lane_o), el);
            if (k == 2) begin
              // R10 idle with changed inputs: outputs hold
              ld_valid_i = 1'b0; st_valid_i = 1'b0;
              ld_word_i = ~w[15:0]; st_result_i = ~r[15:0]; st_orig_i = ~o[15:0];
              ld_addr_lsb_i = ~lsb[0]; st_addr_lsb_i = ~lsb[0];
              @(negedge clk);
              chk("R9 ld_valid low", int'(ld_valid_o), 0);
              chk("R9 st_valid low", int'(st_valid_o), 0);
              chk("R10 ld hold", int'(ld_operand_o), exp_ld(w, md, isw, lsb));
              chk("R10 st hold", int'(st_word_o), ew);
              chk("R10 lane hold", int'(st_lane_o), el);
            end
          end

    // R8 result low byte has no effect on a byte store
    st_valid_i = 1'b1; st_result_i = 16'hC300; st_orig_i = 16'h8E71;
    st_mode_i = 2'b10; st_is_word_i = 1'b0; st_addr_lsb_i = 1'b1;
    @(negedge clk);
    ew = int'(st_word_o);
    st_result_i = 16'hC3FF;
    @(negedge clk);
    chk("R8 low byte ignored", int'(st_word_o), ew);
    chk("R8 low byte ignored value", ew, 16'h8EC3);

    ld_valid_i = 1'b0; st_valid_i = 1'b0;
    @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule